// File: doc/BRIEF.md
# Issue Scoreboard with Outstanding Load Misses

This block sits at the issue point of a scalar pipeline that issues at most one instruction per cycle into three pipes that do not advance in lock step: an ALU pipe, a load/store pipe and a multiply pipe. For each of the 16 architectural registers it records whether a result is still owed by an in-flight load or multiply, and which producer owes it. Each cycle it decides, combinationally, whether the presented candidate instruction may go. For each source operand it also names the path the operand is taken from: the register file, the ALU writeback, the multiply result or the memory return.

Loads take one of four outstanding-read slots and keep it until their data comes back. A load that hits the cache returns two stages after issue. A miss returns later. Either way, independent instructions keep issuing while the miss is pending, and results may come back in any order. Multiplies report their result when it emerges, which may be in any of several stages. Any number of multiplies may be in flight, each to a different register. A dependent instruction is held only while its producer has not yet produced. In the cycle the result appears on a return port, the instruction goes and takes the value from the forwarding path.

Top module: `issue_scoreboard`

## Requirements
- R1: After a synchronous active-high reset, `pend_mask` is all zero and all four load slots are free, so four loads in a row issue in slots 0, 1, 2, 3.
- R2: An issued load or multiply (kind 1 or 2) sets the pending bit of its destination from the next cycle on. An issued ALU op (kind 0) or store (kind 3) leaves `pend_mask` unchanged.
- R3: A candidate whose used source register is pending, with its producer not returning in this cycle, is held (`iss_go` = 0).
- R4: When the pending producer of a used source returns in this cycle, the candidate issues in that same cycle. The operand's forward code is 3 (memory) for a load producer and 2 (multiply) for a multiply producer.
- R5: A load is held while all four slots are busy. A slot whose data returns in a cycle can be given to a load in that same cycle. A load receives the lowest-numbered slot that is free or being freed.
- R6: While loads are outstanding, an instruction that has no pending sources and a non-pending destination issues at once with forward code 0.
- R7: A load, multiply or ALU op whose destination is pending is held unless that producer returns in the same cycle. A store never checks its destination field.
- R8: Forward codes follow a fixed priority when several return ports carry the operand's register: memory (3), then multiply (2), then ALU writeback (1), else register file (0).
- R9: A load return on a busy slot raises `ld_wb_valid` in the same cycle, with `ld_wb_reg` set to that slot's register, and clears its pending bit for the next cycle. A load return on a free slot, or a multiply return for a register not owed by a multiply, changes nothing.
- R10: Pending loads and multiplies may be resolved in any order: each return clears only the register it owns.
- R11: With `iss_valid` low nothing issues and `pend_mask` is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| iss_valid | input | 1 | A candidate instruction is presented |
| iss_kind | input | 2 | 0 ALU, 1 load, 2 multiply, 3 store |
| iss_use_a | input | 1 | Operand A is read |
| iss_src_a | input | 4 | Operand A register |
| iss_use_b | input | 1 | Operand B is read |
| iss_src_b | input | 4 | Operand B register |
| iss_dst | input | 4 | Destination register (ignored for stores) |
| ld_ret_valid | input | 1 | Load data returns this cycle (hit or miss) |
| ld_ret_slot | input | 2 | Slot of the returning load |
| mul_ret_valid | input | 1 | Multiply result emerges this cycle |
| mul_ret_reg | input | 4 | Destination of the emerging multiply result |
| alu_wb_valid | input | 1 | ALU pipe writes back this cycle |
| alu_wb_reg | input | 4 | Register of the ALU writeback |
| iss_go | output | 1 | Candidate issues this cycle |
| iss_slot | output | 2 | Slot given to an issuing load |
| fwd_a | output | 2 | Operand A source: 0 file, 1 ALU, 2 multiply, 3 memory |
| fwd_b | output | 2 | Operand B source, same codes |
| ld_wb_valid | output | 1 | Memory pipe register-file write this cycle |
| ld_wb_reg | output | 4 | Register of that write |
| pend_mask | output | 16 | One bit per register still owed a result |

## Verification
The collisions that matter are a result return landing in the same cycle as the issue that depends on it. In one case a load return frees a slot while a fifth load waits. In the other, a pending source or destination is resolved just as its consumer is presented. The bench drives the return and the candidate in one cycle. It expects the issue in that cycle, with the freed slot number or the memory/multiply forward code. It then reads `pend_mask` a cycle later to confirm that the new owner's bit survived and the old owner's bit was cleared.

// File: rtl/sb_pkg.sv
package sb_pkg;
    localparam int NUM_REGS  = 16;
    localparam int NUM_SLOTS = 4;
    localparam int RW = $clog2(NUM_REGS);
    localparam int SW = $clog2(NUM_SLOTS);

    typedef enum logic [1:0] {K_ALU = 2'd0, K_LOAD = 2'd1, K_MUL = 2'd2, K_STORE = 2'd3} kind_e;
    typedef enum logic [1:0] {FW_RF = 2'd0, FW_ALU = 2'd1, FW_MUL = 2'd2, FW_MEM = 2'd3} fwd_e;

    typedef struct packed {
        logic          busy;
        logic          by_mul;
        logic [SW-1:0] slot;
    } pend_t;

    typedef struct packed {
        kind_e         kind;
        logic          use_a;
        logic [RW-1:0] src_a;
        logic          use_b;
        logic [RW-1:0] src_b;
        logic [RW-1:0] dst;
    } issue_req_t;

    typedef struct packed {
        logic          valid;
        logic [RW-1:0] rnum;
    } ret_t;

    function automatic fwd_e pick_fwd(input logic [RW-1:0] r, input ret_t mem,
                                      input ret_t mul, input ret_t alu);
        if (mem.valid && mem.rnum == r)      return FW_MEM;
        else if (mul.valid && mul.rnum == r) return FW_MUL;
        else if (alu.valid && alu.rnum == r) return FW_ALU;
        else                                 return FW_RF;
    endfunction

    function automatic logic makes_pending(input kind_e k);
        return (k == K_LOAD) || (k == K_MUL);
    endfunction
endpackage

// File: rtl/sb_slotpool.sv
module sb_slotpool
    import sb_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 alloc,
    input  logic [RW-1:0]        alloc_reg,
    input  logic                 ret_valid,
    input  logic [SW-1:0]        ret_slot,
    output logic [NUM_SLOTS-1:0] busy_vec,
    output logic                 free_any,
    output logic [SW-1:0]        free_idx,
    output logic                 retire,
    output logic [RW-1:0]        retire_reg
);
    logic [NUM_SLOTS-1:0] busy_q;
    logic [RW-1:0]        reg_q [NUM_SLOTS];
    logic [NUM_SLOTS-1:0] avail;

    assign retire     = ret_valid && busy_q[ret_slot];
    assign retire_reg = reg_q[ret_slot];
    assign busy_vec   = busy_q;

    generate
        for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_avail
            assign avail[i] = !busy_q[i] || (retire && ret_slot == SW'(i));
        end
    endgenerate

    assign free_any = |avail;

    always_comb begin
        free_idx = '0;
        for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
            if (avail[i]) free_idx = SW'(i);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= '0;
            for (int i = 0; i < NUM_SLOTS; i++) reg_q[i] <= '0;
        end else begin
            if (retire) busy_q[ret_slot] <= 1'b0;
            if (alloc) begin
                busy_q[free_idx] <= 1'b1;
                reg_q[free_idx]  <= alloc_reg;
            end
        end
    end
endmodule

// File: rtl/sb_regtrack.sv
module sb_regtrack
    import sb_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                ld_retire,
    input  logic [SW-1:0]       ld_slot,
    input  logic                mul_valid,
    input  logic [RW-1:0]       mul_reg,
    input  logic                set_valid,
    input  logic [RW-1:0]       set_reg,
    input  logic                set_by_mul,
    input  logic [SW-1:0]       set_slot,
    output logic [NUM_REGS-1:0] pend_mask,
    output logic [NUM_REGS-1:0] resolve
);
    pend_t tbl [NUM_REGS];

    generate
        for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
            logic ld_hit, mul_hit;
            assign ld_hit     = ld_retire && !tbl[r].by_mul && tbl[r].slot == ld_slot;
            assign mul_hit    = mul_valid && tbl[r].by_mul && mul_reg == RW'(r);
            assign resolve[r] = tbl[r].busy && (ld_hit || mul_hit);
            assign pend_mask[r] = tbl[r].busy;

            always_ff @(posedge clk) begin
                if (rst) begin
                    tbl[r] <= '0;
                end else if (set_valid && set_reg == RW'(r)) begin
                    tbl[r] <= '{busy: 1'b1, by_mul: set_by_mul, slot: set_slot};
                end else if (resolve[r]) begin
                    tbl[r].busy <= 1'b0;
                end
            end
        end
    endgenerate
endmodule

// File: rtl/sb_hazard.sv
module sb_hazard
    import sb_pkg::*;
(
    input  logic                iss_valid,
    input  issue_req_t          req,
    input  logic [NUM_REGS-1:0] pend_mask,
    input  logic [NUM_REGS-1:0] resolve,
    input  logic                free_any,
    input  ret_t                mem_ret,
    input  ret_t                mul_ret,
    input  ret_t                alu_ret,
    output logic                go,
    output fwd_e                fwd_a,
    output fwd_e                fwd_b
);
    logic [NUM_REGS-1:0] blocked;
    logic raw, waw, full;

    assign blocked = pend_mask & ~resolve;
    assign raw  = (req.use_a && blocked[req.src_a]) || (req.use_b && blocked[req.src_b]);
    assign waw  = (req.kind != K_STORE) && blocked[req.dst];
    assign full = (req.kind == K_LOAD) && !free_any;
    assign go   = iss_valid && !raw && !waw && !full;

    assign fwd_a = pick_fwd(req.src_a, mem_ret, mul_ret, alu_ret);
    assign fwd_b = pick_fwd(req.src_b, mem_ret, mul_ret, alu_ret);
endmodule

// File: rtl/issue_scoreboard.sv
module issue_scoreboard
    import sb_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                iss_valid,
    input  logic [1:0]          iss_kind,
    input  logic                iss_use_a,
    input  logic [RW-1:0]       iss_src_a,
    input  logic                iss_use_b,
    input  logic [RW-1:0]       iss_src_b,
    input  logic [RW-1:0]       iss_dst,
    input  logic                ld_ret_valid,
    input  logic [SW-1:0]       ld_ret_slot,
    input  logic                mul_ret_valid,
    input  logic [RW-1:0]       mul_ret_reg,
    input  logic                alu_wb_valid,
    input  logic [RW-1:0]       alu_wb_reg,
    output logic                iss_go,
    output logic [SW-1:0]       iss_slot,
    output logic [1:0]          fwd_a,
    output logic [1:0]          fwd_b,
    output logic                ld_wb_valid,
    output logic [RW-1:0]       ld_wb_reg,
    output logic [NUM_REGS-1:0] pend_mask
);
    issue_req_t           req;
    logic [NUM_SLOTS-1:0] slot_busy;
    logic [NUM_REGS-1:0]  resolve;
    logic                 free_any;
    logic                 retire;
    logic [RW-1:0]        retire_reg;
    logic                 set_pend;
    fwd_e                 fa, fb;
    ret_t                 mem_ret, mul_ret, alu_ret;

    assign req = '{kind: kind_e'(iss_kind), use_a: iss_use_a, src_a: iss_src_a,
                   use_b: iss_use_b, src_b: iss_src_b, dst: iss_dst};

    assign mem_ret = '{valid: retire, rnum: retire_reg};
    assign mul_ret = '{valid: mul_ret_valid, rnum: mul_ret_reg};
    assign alu_ret = '{valid: alu_wb_valid, rnum: alu_wb_reg};

    assign set_pend = iss_go && makes_pending(req.kind);

    sb_slotpool u_slots (
        .clk        (clk),
        .rst        (rst),
        .alloc      (iss_go && req.kind == K_LOAD),
        .alloc_reg  (req.dst),
        .ret_valid  (ld_ret_valid),
        .ret_slot   (ld_ret_slot),
        .busy_vec   (slot_busy),
        .free_any   (free_any),
        .free_idx   (iss_slot),
        .retire     (retire),
        .retire_reg (retire_reg)
    );

    sb_regtrack u_track (
        .clk        (clk),
        .rst        (rst),
        .ld_retire  (retire),
        .ld_slot    (ld_ret_slot),
        .mul_valid  (mul_ret_valid),
        .mul_reg    (mul_ret_reg),
        .set_valid  (set_pend),
        .set_reg    (req.dst),
        .set_by_mul (req.kind == K_MUL),
        .set_slot   (iss_slot),
        .pend_mask  (pend_mask),
        .resolve    (resolve)
    );

    sb_hazard u_haz (
        .iss_valid (iss_valid),
        .req       (req),
        .pend_mask (pend_mask),
        .resolve   (resolve),
        .free_any  (free_any),
        .mem_ret   (mem_ret),
        .mul_ret   (mul_ret),
        .alu_ret   (alu_ret),
        .go        (iss_go),
        .fwd_a     (fa),
        .fwd_b     (fb)
    );

    assign fwd_a       = fa;
    assign fwd_b       = fb;
    assign ld_wb_valid = retire;
    assign ld_wb_reg   = retire_reg;
endmodule

// File: rtl/issue_scoreboard_chk.sv
module issue_scoreboard_chk
    import sb_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 iss_valid,
    input logic [1:0]           iss_kind,
    input logic                 iss_use_a,
    input logic [RW-1:0]        iss_src_a,
    input logic [RW-1:0]        iss_dst,
    input logic                 ld_ret_valid,
    input logic [SW-1:0]        ld_ret_slot,
    input logic                 iss_go,
    input logic [SW-1:0]        iss_slot,
    input logic [1:0]           fwd_a,
    input logic                 ld_wb_valid,
    input logic [RW-1:0]        ld_wb_reg,
    input logic [NUM_REGS-1:0]  pend_mask,
    input logic [NUM_SLOTS-1:0] slot_busy
);
    logic issue_pends;
    assign issue_pends = iss_go && (iss_kind == 2'd1 || iss_kind == 2'd2);

    a_r11_idle_no_issue: assert property (@(posedge clk) disable iff (rst)
        !iss_valid |-> !iss_go);

    a_r2_pending_set: assert property (@(posedge clk) disable iff (rst)
        issue_pends |=> pend_mask[$past(iss_dst)]);

    a_r3_pending_src_forwarded: assert property (@(posedge clk) disable iff (rst)
        (iss_go && iss_use_a && pend_mask[iss_src_a]) |-> (fwd_a == 2'd3 || fwd_a == 2'd2));

    a_r5_slot_available: assert property (@(posedge clk) disable iff (rst)
        (iss_go && iss_kind == 2'd1) |->
            (!slot_busy[iss_slot] || (ld_wb_valid && ld_ret_slot == iss_slot)));

    a_r9_free_slot_ignored: assert property (@(posedge clk) disable iff (rst)
        (ld_ret_valid && !slot_busy[ld_ret_slot]) |-> !ld_wb_valid);

    a_r9_return_clears: assert property (@(posedge clk) disable iff (rst)
        (ld_wb_valid && !(issue_pends && iss_dst == ld_wb_reg)) |=> !pend_mask[$past(ld_wb_reg)]);
endmodule

bind issue_scoreboard issue_scoreboard_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .iss_valid    (iss_valid),
    .iss_kind     (iss_kind),
    .iss_use_a    (iss_use_a),
    .iss_src_a    (iss_src_a),
    .iss_dst      (iss_dst),
    .ld_ret_valid (ld_ret_valid),
    .ld_ret_slot  (ld_ret_slot),
    .iss_go       (iss_go),
    .iss_slot     (iss_slot),
    .fwd_a        (fwd_a),
    .ld_wb_valid  (ld_wb_valid),
    .ld_wb_reg    (ld_wb_reg),
    .pend_mask    (pend_mask),
    .slot_busy    (slot_busy)
);

// File: tb/issue_scoreboard_tb.sv
module issue_scoreboard_tb;
    localparam int CLK_PERIOD = 10;
    localparam logic [1:0] KA = 2'd0, KL = 2'd1, KM = 2'd2, KS = 2'd3;

    logic clk = 1'b0;
    logic rst;
    logic iss_valid, iss_use_a, iss_use_b;
    logic [1:0] iss_kind;
    logic [3:0] iss_src_a, iss_src_b, iss_dst;
    logic ld_ret_valid, mul_ret_valid, alu_wb_valid;
    logic [1:0] ld_ret_slot;
    logic [3:0] mul_ret_reg, alu_wb_reg;
    logic iss_go, ld_wb_valid;
    logic [1:0] iss_slot, fwd_a, fwd_b;
    logic [3:0] ld_wb_reg;
    logic [15:0] pend_mask;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    issue_scoreboard u_dut (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic clear_in();
        iss_valid = 0; iss_kind = KA; iss_use_a = 0; iss_src_a = 0;
        iss_use_b = 0; iss_src_b = 0; iss_dst = 0;
        ld_ret_valid = 0; ld_ret_slot = 0; mul_ret_valid = 0; mul_ret_reg = 0;
        alu_wb_valid = 0; alu_wb_reg = 0;
    endtask

    // advance one clock, leave inputs idle just after the falling edge
    task automatic cyc();
        @(negedge clk);
        clear_in();
    endtask

    task automatic cand(input logic [1:0] k, input logic ua, input logic [3:0] a,
                        input logic ub, input logic [3:0] b, input logic [3:0] d);
        iss_valid = 1; iss_kind = k; iss_use_a = ua; iss_src_a = a;
        iss_use_b = ub; iss_src_b = b; iss_dst = d;
    endtask

    task automatic do_reset();
        @(negedge clk);
        clear_in();
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
    endtask

    task automatic t_loads();
        do_reset();
        #1 chk("R1 reset pend_mask", pend_mask, 0);
        for (int i = 0; i < 4; i++) begin
            cyc(); cand(KL, 0, 0, 0, 0, 4'(i + 1)); #1;
            chk("R1 load issues after reset", iss_go, 1);
            chk("R5 lowest free slot", iss_slot, i);
        end
        cyc(); #1 chk("R2 load dsts pending", pend_mask, 16'h001E);
        cand(KL, 0, 0, 0, 0, 5); #1 chk("R5 fifth load held", iss_go, 0);
        cyc(); cand(KA, 1, 6, 1, 7, 8); #1;
        chk("R6 independent issues under misses", iss_go, 1);
        chk("R6 forward from file", fwd_a, 0);
        cyc(); #1 chk("R2 ALU leaves mask", pend_mask, 16'h001E);
        cand(KA, 1, 6, 1, 2, 8); #1 chk("R3 pending source held", iss_go, 0);
        cyc(); cand(KL, 0, 0, 0, 0, 5); ld_ret_valid = 1; ld_ret_slot = 1; #1;
        chk("R5 load takes slot freed now", iss_go, 1);
        chk("R5 freed slot number", iss_slot, 1);
        chk("R9 wb valid", ld_wb_valid, 1);
        chk("R9 wb reg", ld_wb_reg, 2);
        cyc(); #1 chk("R10 out-of-order clear", pend_mask, 16'h003A);
        cand(KA, 1, 3, 0, 0, 9); ld_ret_valid = 1; ld_ret_slot = 2; #1;
        chk("R4 load return releases consumer", iss_go, 1);
        chk("R4 memory forward code", fwd_a, 3);
        cyc(); #1 chk("R9 slot2 cleared r3", pend_mask, 16'h0032);
        ld_ret_valid = 1; ld_ret_slot = 2; #1;
        chk("R9 free slot return ignored wb", ld_wb_valid, 0);
        cyc(); #1 chk("R9 free slot return mask kept", pend_mask, 16'h0032);
        cand(KA, 0, 0, 0, 0, 4); #1 chk("R7 pending dst held", iss_go, 0);
        cyc(); cand(KA, 0, 0, 0, 0, 4); ld_ret_valid = 1; ld_ret_slot = 3; #1;
        chk("R7 dst released by return", iss_go, 1);
        cyc(); #1 chk("R10 r4 cleared", pend_mask, 16'h0022);
    endtask

    task automatic t_muls();
        do_reset();
        for (int i = 1; i <= 3; i++) begin
            cyc(); cand(KM, 0, 0, 0, 0, 4'(i)); #1 chk("R10 mul issues", iss_go, 1);
        end
        cyc(); #1 chk("R2 mul dsts pending", pend_mask, 16'h000E);
        mul_ret_valid = 1; mul_ret_reg = 2;
        cyc(); #1 chk("R10 middle mul done first", pend_mask, 16'h000A);
        cand(KL, 0, 0, 0, 0, 1); #1 chk("R7 load to mul dst held", iss_go, 0);
        cyc(); cand(KA, 1, 1, 0, 0, 9); mul_ret_valid = 1; mul_ret_reg = 1; #1;
        chk("R4 mul return releases consumer", iss_go, 1);
        chk("R4 multiply forward code", fwd_a, 2);
        cyc(); #1 chk("R10 r1 cleared", pend_mask, 16'h0008);
        mul_ret_valid = 1; mul_ret_reg = 2;
        cyc(); #1 chk("R9 stray mul return ignored", pend_mask, 16'h0008);
        cand(KL, 0, 0, 0, 0, 5);
        cyc(); #1 chk("R2 load r5 pending", pend_mask, 16'h0028);
        mul_ret_valid = 1; mul_ret_reg = 5;
        cyc(); #1 chk("R9 mul return on load reg ignored", pend_mask, 16'h0028);
    endtask

    task automatic t_priority();
        do_reset();
        cyc(); cand(KL, 0, 0, 0, 0, 7);
        cyc(); cand(KA, 1, 7, 1, 10, 11);
        ld_ret_valid = 1; ld_ret_slot = 0; mul_ret_valid = 1; mul_ret_reg = 7;
        alu_wb_valid = 1; alu_wb_reg = 7; #1;
        chk("R8 memory beats multiply and ALU", fwd_a, 3);
        chk("R8 unmatched operand from file", fwd_b, 0);
        cyc(); cand(KA, 1, 7, 1, 9, 11);
        mul_ret_valid = 1; mul_ret_reg = 7; alu_wb_valid = 1; alu_wb_reg = 7; #1;
        chk("R8 multiply beats ALU", fwd_a, 2);
        chk("R8 file when no match", fwd_b, 0);
        cyc(); cand(KA, 1, 12, 1, 9, 11); alu_wb_valid = 1; alu_wb_reg = 9; #1;
        chk("R8 ALU forward", fwd_b, 1);
        chk("R6 ALU forward issues", iss_go, 1);
    endtask

    task automatic t_idle();
        do_reset();
        cyc(); cand(KM, 0, 0, 0, 0, 3);
        cyc(); iss_kind = KL; iss_dst = 6; #1 chk("R11 no issue when invalid", iss_go, 0);
        cyc(); #1 chk("R11 mask unchanged", pend_mask, 16'h0008);
        cand(KS, 1, 1, 1, 2, 3); #1 chk("R7 store ignores dst field", iss_go, 1);
        cyc(); #1 chk("R2 store leaves mask", pend_mask, 16'h0008);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        failures++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst = 1;
        clear_in();
        t_loads();
        t_muls();
        t_priority();
        t_idle();
        cyc();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule